// File: doc/BRIEF.md
# Three-Voice Square Tone Mixer

This block makes three square-wave tones, each with its own period, loudness and mute bit. It adds them into one signed 16-bit audio sample. Each voice counts down a 16-bit counter once per step. The counter reloads from the voice's 12-bit period multiplied by sixteen, and the voice's phase bit flips on every reload. While the phase bit is high, the voice contributes its 4-bit level. The level is looked up in a table that falls by half a power of two per level below the top, and the sum of the three lookups is emitted negated.

A processor reaches the sixteen internal registers through a pair of ports. A write with `wr_addr` = 0 stores an index, and a write with `wr_addr` = 1 stores a byte into the register that index names. The sample is registered and changes one cycle after a voice level changes. Voices move only on cycles where `step_en` is high.

Top module: `sqt_tone3`

## Requirements
- R1: On each step, a voice's counter drops by one, wrapping modulo 65536. When the result is zero, the counter reloads with the voice's period times 16 and the voice's phase bit inverts.
- R2: After each step, a voice's level is its volume when its phase bit (after the step) is 1, and 0 when the phase bit is 0.
- R3: Register 7 bits 0, 1 and 2 mute voices 0, 1 and 2 (1 = muted). A voice that is muted at a step outputs level 0.
- R4: A write with `wr_addr` = 0 keeps only `wr_data[3:0]` as the register index. A write with `wr_addr` = 1 stores into the register that index selects.
- R5: Registers 0, 2 and 4 set bits 7:0 of the periods of voices 0, 1 and 2. Registers 1, 3 and 5 set period bits 11:8 from `wr_data[3:0]`, and the upper data bits are dropped.
- R6: Registers 8, 9 and 10 set the volumes of voices 0, 1 and 2 from `wr_data[3:0]`.
- R7: Writes to registers 6 and 11 through 15 change no state.
- R8: The gain for level n is the integer part of 8192 / 2^((15-n)/2); level 15 gives 8192 and level 0 gives 45. The value of `sample_o` one cycle after a set of levels is the two's complement negation of the sum of their three gains.
- R9: While `rst` is high, all voices are muted with period 1, and volume, counter, phase bit and level are 0. The index is 0 and `sample_o` is 0.
- R10: A period written while a voice is counting is used only at that voice's next reload. The running count is not changed.
- R11: While `step_en` is low, counters, phase bits and levels hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance all voices one step this cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = index port, 1 = data port |
| wr_data | input | 8 | Write byte |
| sample_o | output | 16 | Signed mixed sample, negated sum of gains |

## Verification
The three voices run together with short, two-step and odd mid-size periods. This separates a wrong reload scale or a missing toggle per voice, and a reference model predicts every sample. A sweep of one voice through all sixteen volume levels exposes any wrong table entry. Mute patterns, a period rewrite in mid-count, gated and alternate-cycle stepping, and writes to unused indices each show up as a different sample stream. Writes with junk in the upper bits show whether the index and the high-part period writes drop those bits.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

  typedef enum logic {
    PORT_IDX = 1'b0,
    PORT_DAT = 1'b1
  } port_e;

  // integer square root, bitwise
  function automatic longint unsigned sqt_isqrt(input longint unsigned v);
    longint unsigned r;
    longint unsigned t;
    r = 0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (longint'(1) << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  // gain for level lvl: floor(2^fs / 2^((maxl-lvl)/2))
  function automatic int unsigned sqt_gain(input int unsigned lvl,
                                           input int unsigned maxl,
                                           input int unsigned fs);
    int unsigned d;
    int unsigned k;
    longint unsigned odd_base;
    d = maxl - lvl;
    k = d / 2;
    odd_base = sqt_isqrt(longint'(1) << (2 * fs - 1));
    if (d % 2 == 1) return int'(odd_base >> k);
    return int'((longint'(1) << fs) >> k);
  endfunction

endpackage

// File: rtl/sqt_regs.sv
module sqt_regs #(
  parameter int CH_N  = 3,
  parameter int PER_W = 12,
  parameter int VOL_W = 4,
  parameter int IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        wr_addr,
  input  logic [7:0]                  wr_data,
  output logic [CH_N-1:0][PER_W-1:0]  period_o,
  output logic [CH_N-1:0][VOL_W-1:0]  volume_o,
  output logic [CH_N-1:0]             mute_o
);
  import sqt_pkg::*;

  localparam int REG_MUTE = 2 * CH_N + 1;
  localparam int REG_VOL0 = 2 * CH_N + 2;
  localparam int HI_W     = PER_W - 8;

  logic [IDX_W-1:0]            idx_q;
  logic [CH_N-1:0][PER_W-1:0]  per_q;
  logic [CH_N-1:0][VOL_W-1:0]  vol_q;
  logic [CH_N-1:0]             mute_q;
  logic                        idx_wr, dat_wr;

  assign idx_wr = wr_en && (port_e'(wr_addr) == PORT_IDX);
  assign dat_wr = wr_en && (port_e'(wr_addr) == PORT_DAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      mute_q <= '1;
      vol_q  <= '0;
      for (int c = 0; c < CH_N; c++) per_q[c] <= PER_W'(1);
    end else if (idx_wr) begin
      idx_q <= wr_data[IDX_W-1:0];
    end else if (dat_wr) begin
      for (int c = 0; c < CH_N; c++) begin
        if (idx_q == IDX_W'(2 * c))        per_q[c][7:0]       <= wr_data;
        if (idx_q == IDX_W'(2 * c + 1))    per_q[c][PER_W-1:8] <= wr_data[HI_W-1:0];
        if (idx_q == IDX_W'(REG_VOL0 + c)) vol_q[c]            <= wr_data[VOL_W-1:0];
      end
      if (idx_q == IDX_W'(REG_MUTE)) mute_q <= wr_data[CH_N-1:0];
    end
  end

  assign period_o = per_q;
  assign volume_o = vol_q;
  assign mute_o   = mute_q;

  logic idx_dead;
  assign idx_dead = (idx_q == IDX_W'(2 * CH_N)) || (idx_q >= IDX_W'(REG_VOL0 + CH_N));

  a_r7_dead_index: assert property (@(posedge clk) disable iff (rst)
    dat_wr && idx_dead |=> $stable(per_q) && $stable(vol_q) && $stable(mute_q));

  a_r4_index_low: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> idx_q == $past(wr_data[IDX_W-1:0]));

  a_r4_data_keeps_index: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> $stable(idx_q));

endmodule

// File: rtl/sqt_voice.sv
module sqt_voice #(
  parameter int PER_W  = 12,
  parameter int VOL_W  = 4,
  parameter int PSC_SH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [PER_W-1:0] period_i,
  input  logic [VOL_W-1:0] volume_i,
  input  logic             mute_i,
  output logic [VOL_W-1:0] lvl_o
);
  localparam int CNT_W = PER_W + PSC_SH;

  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             duty_q, duty_nx, wrap;
  logic [VOL_W-1:0] lvl_q;

  always_comb begin
    cnt_dec = cnt_q - 1'b1;
    wrap    = (cnt_dec == '0);
    duty_nx = wrap ? ~duty_q : duty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= 1'b0;
      lvl_q  <= '0;
    end else if (step_en) begin
      cnt_q  <= wrap ? {period_i, {PSC_SH{1'b0}}} : cnt_dec;
      duty_q <= duty_nx;
      lvl_q  <= (mute_i || !duty_nx) ? '0 : volume_i;
    end
  end

  assign lvl_o = lvl_q;

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(cnt_q) && $stable(duty_q) && $stable(lvl_q));

  a_r1_flip_on_reload: assert property (@(posedge clk) disable iff (rst)
    step_en && cnt_q == CNT_W'(1) |=> duty_q != $past(duty_q));

  a_r10_no_early_load: assert property (@(posedge clk) disable iff (rst)
    step_en && cnt_q != CNT_W'(1) |=> cnt_q == $past(cnt_q) - 1'b1 && duty_q == $past(duty_q));

  a_r3_muted_silent: assert property (@(posedge clk) disable iff (rst)
    step_en && mute_i |=> lvl_q == '0);

endmodule

// File: rtl/sqt_mix.sv
module sqt_mix #(
  parameter int CH_N    = 3,
  parameter int VOL_W   = 4,
  parameter int OUT_W   = 16,
  parameter int FS_LOG2 = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CH_N-1:0][VOL_W-1:0] lvl_i,
  output logic [OUT_W-1:0]           sample_o
);
  localparam int LVLS  = 2 ** VOL_W;
  localparam int SUM_W = OUT_W + 2;

  logic [OUT_W-1:0] gain_rom [LVLS];

  for (genvar g = 0; g < LVLS; g++) begin : g_rom
    assign gain_rom[g] = OUT_W'(sqt_pkg::sqt_gain(g, LVLS - 1, FS_LOG2));
  end

  logic [SUM_W-1:0] acc, neg;
  logic [OUT_W-1:0] sample_q;

  always_comb begin
    acc = '0;
    for (int c = 0; c < CH_N; c++) acc = acc + SUM_W'(gain_rom[lvl_i[c]]);
    neg = -acc;
  end

  always_ff @(posedge clk) begin
    if (rst) sample_q <= '0;
    else     sample_q <= neg[OUT_W-1:0];
  end

  assign sample_o = sample_q;

  a_r8_negative: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sample_q[OUT_W-1] == 1'b1);

  a_r8_follows_levels: assert property (@(posedge clk) disable iff (rst)
    $stable(lvl_i) && !$fell(rst) |=> $stable(sample_q));

endmodule

// File: rtl/sqt_tone3.sv
module sqt_tone3 #(
  parameter int CH_N    = 3,
  parameter int PER_W   = 12,
  parameter int VOL_W   = 4,
  parameter int PSC_SH  = 4,
  parameter int IDX_W   = 4,
  parameter int OUT_W   = 16,
  parameter int FS_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  output logic [OUT_W-1:0] sample_o
);
  logic [CH_N-1:0][PER_W-1:0] period;
  logic [CH_N-1:0][VOL_W-1:0] volume;
  logic [CH_N-1:0]            mute;
  logic [CH_N-1:0][VOL_W-1:0] lvl;

  sqt_regs #(.CH_N(CH_N), .PER_W(PER_W), .VOL_W(VOL_W), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .period_o (period),
    .volume_o (volume),
    .mute_o   (mute)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_voice
    sqt_voice #(.PER_W(PER_W), .VOL_W(VOL_W), .PSC_SH(PSC_SH)) u_voice (
      .clk      (clk),
      .rst      (rst),
      .step_en  (step_en),
      .period_i (period[c]),
      .volume_i (volume[c]),
      .mute_i   (mute[c]),
      .lvl_o    (lvl[c])
    );
  end

  sqt_mix #(.CH_N(CH_N), .VOL_W(VOL_W), .OUT_W(OUT_W), .FS_LOG2(FS_LOG2)) u_mix (
    .clk      (clk),
    .rst      (rst),
    .lvl_i    (lvl),
    .sample_o (sample_o)
  );

endmodule

// File: tb/tb_sqt_tone3.sv
module tb_sqt_tone3;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [15:0] sample_o;

  always #4 clk = ~clk;

  sqt_tone3 dut (
    .clk(clk), .rst(rst), .step_en(step_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sample_o(sample_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R9";

  // scoreboard queues
  int    exp_q[$];
  string tag_q[$];

  // reference state from the requirements
  int gain [16];
  int m_per[3], m_vol[3], m_mute[3], m_cnt[3], m_duty[3], m_lvl[3];
  int m_idx;

  initial begin
    for (int n = 0; n < 16; n++) gain[n] = $rtoi(8192.0 / (2.0 ** ((15 - n) / 2.0)));
  end

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0;
      for (int c = 0; c < 3; c++) begin
        m_per[c] = 1; m_vol[c] = 0; m_mute[c] = 1;
        m_cnt[c] = 0; m_duty[c] = 0; m_lvl[c] = 0;
      end
      exp_q.push_back(0);
      tag_q.push_back(tag);
    end else begin
      exp_q.push_back(-(gain[m_lvl[0]] + gain[m_lvl[1]] + gain[m_lvl[2]]));
      tag_q.push_back(tag);
      if (step_en) begin
        for (int c = 0; c < 3; c++) begin
          m_cnt[c] = (m_cnt[c] - 1) & 16'hFFFF;
          if (m_cnt[c] == 0) begin
            m_cnt[c]  = (m_per[c] << 4) & 16'hFFFF;
            m_duty[c] = 1 - m_duty[c];
          end
          m_lvl[c] = (m_mute[c] != 0 || m_duty[c] == 0) ? 0 : m_vol[c];
        end
      end
      if (wr_en && !wr_addr) m_idx = wr_data & 15;
      else if (wr_en && wr_addr) begin
        for (int c = 0; c < 3; c++) begin
          if (m_idx == 2 * c)     m_per[c] = (m_per[c] & 12'hF00) | wr_data;
          if (m_idx == 2 * c + 1) m_per[c] = (m_per[c] & 12'h0FF) | ((wr_data & 15) << 8);
          if (m_idx == 8 + c)     m_vol[c] = wr_data & 15;
        end
        if (m_idx == 7)
          for (int c = 0; c < 3; c++) m_mute[c] = (wr_data >> c) & 1;
      end
    end
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ($signed(sample_o) !== 16'(e)) begin
        errors++;
        $display("FAIL %s sample got %0d expected %0d", t, $signed(sample_o), e);
      end
    end
  end

  task automatic put(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx_byte, input logic [7:0] d);
    put(1'b0, idx_byte);
    put(1'b1, d);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    tag = "R9"; rst = 1'b1;
    run(4);
    rst = 1'b0;
    run(3);
    // R4: upper index bits dropped; R5: high-part upper bits dropped
    tag = "R4";
    wreg(8'hE0, 8'h01);
    tag = "R5";
    wreg(8'h91, 8'hF0);
    wreg(8'h02, 8'h02);
    wreg(8'h33, 8'h00);
    wreg(8'h04, 8'h13);
    wreg(8'hC5, 8'hA0);
    tag = "R6";
    wreg(8'h08, 8'h1F);
    wreg(8'h09, 8'hA7);
    wreg(8'h0A, 8'h33);
    tag = "R7";
    wreg(8'h06, 8'hFF);
    for (int i = 11; i < 16; i++) wreg(8'(i), 8'hFF);
    tag = "R3";
    wreg(8'h07, 8'hF8);
    // R11: no stepping
    tag = "R11";
    run(30);
    // R1/R2: free run through first wrap and many reloads
    tag = "R1";
    step_en = 1'b1;
    run(65536 + 1500);
    tag = "R2";
    run(500);
    // R11: alternate-cycle stepping
    tag = "R11";
    for (int i = 0; i < 1000; i++) begin
      step_en = i[0];
      @(negedge clk);
    end
    step_en = 1'b1;
    // R8: sweep voice 0 through every level
    tag = "R8";
    for (int v = 0; v < 16; v++) begin
      wreg(8'h08, 8'(v));
      run(100);
    end
    // R3: mute patterns
    tag = "R3";
    wreg(8'h07, 8'h02); run(400);
    wreg(8'h07, 8'h07); run(100);
    wreg(8'h07, 8'h05); run(300);
    wreg(8'h07, 8'h00);
    // R10: period rewrite mid-count
    tag = "R10";
    run(37);
    wreg(8'h04, 8'h40);
    run(1500);
    wreg(8'h05, 8'h01);
    wreg(8'h00, 8'h05);
    run(9000);
    // R7 again while running
    tag = "R7";
    for (int i = 11; i < 16; i++) wreg(8'(i), 8'h00);
    wreg(8'h06, 8'h00);
    run(400);
    // R9: reset mid-run
    tag = "R9";
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(200);
    step_en = 1'b0;
    run(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule